// File: doc/BRIEF.md
# Handshaked Serial Bit-Buffer Reader

This block sits on the controller side of a three-wire link to a remote bit buffer. The link carries a clock that the host drives, a data line, and a ready flag that the buffer raises while it holds unread bits. The reader keeps its clock output low until ready is high. It then gives one clock pulse per bit and takes the data bit on the falling edge. After each pulse it waits out a settling delay and looks at ready again. It stops as soon as ready reads low. The received bits are packed most-significant first into words, which leave the block on a valid/ready stream.

The link can also run with the remote side generating the clock. A mode output says which side owns the clock: 1 means the host, 0 means the remote. In remote-clocked mode the reader keeps its clock output low and takes bits on the falling edges of the remote clock. The word assembly carries on unbroken across both handover directions. The takeover from the remote side and the release back to it both follow a timed handshake. A step that runs past its window sets a sticky error flag.

All pulse widths, the settling delay and the handover window are counts of the system clock, set by parameters.

Top module: `rdr_host_reader`

## Requirements
- R1: While reset is asserted and after it is released, mode_o is 1 (the host owns the clock), sclk_o is 0, byte_valid_o is 0 and err_o is 0.
- R2: sclk_o only rises in the cycle after a cycle in which rdy_i was high. While rdy_i stays low, sclk_o stays low.
- R3: Each high phase of sclk_o lasts exactly HI_CYC cycles. Between a falling edge and the next rising edge there are at least max(LO_CYC, SETTLE_CYC)+1 low cycles, and ready is sampled only after that wait.
- R4: In host mode each clock pulse takes exactly one bit. Once the buffer is empty, no further pulse is issued.
- R5: Bits are packed MSB first: the first bit received becomes bit 7 of the word. A word is offered on byte_o/byte_valid_o after every eighth bit.
- R6: A word that is offered stays valid and unchanged until byte_ready_i is high. Suppose a word is waiting and seven bits of the next word are already held. Then no clock pulse is issued until the waiting word is taken, so after 24 bits are made available with the stream stalled, exactly 15 pulses occur.
- R7: Ready may stay low for any length of time, also while the reader waits to hand the clock back. This never sets err_o.
- R8: When mode_o is 0, sclk_o stays low. Bits are taken on falling edges of dev_clk_i and join the same word assembly.
- R9: After a one-cycle take_req_i pulse in remote mode, the reader takes the bit on the next falling edge of dev_clk_i and then sets mode_o to 1. Host clocking then continues with the next bit, so no bit is lost or repeated.
- R10: After a one-cycle give_req_i pulse in host mode, the reader first drains the buffer. It then keeps mode_o at 1 until ready rises again. Next it clocks out the available bits and clears mode_o once ready reads low after a pulse. This release happens within TMS_CYC cycles of that ready rise.
- R11: If a takeover sees no falling edge of dev_clk_i within TMS_CYC cycles, err_o goes to 1 and stays there until reset, and mode_o stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rdy_i | input | 1 | Remote buffer holds unread bits |
| dat_i | input | 1 | Serial data from the remote buffer |
| dev_clk_i | input | 1 | Clock as driven by the remote side in remote mode |
| sclk_o | output | 1 | Host-driven serial clock |
| mode_o | output | 1 | 1: host owns the clock, 0: remote owns it |
| take_req_i | input | 1 | Pulse: take over clocking from the remote side |
| give_req_i | input | 1 | Pulse: hand clocking back to the remote side |
| byte_o | output | W | Assembled word |
| byte_valid_o | output | 1 | Word on byte_o is valid |
| byte_ready_i | input | 1 | Consumer accepts the word |
| err_o | output | 1 | Sticky handover timeout flag |

## Verification
The assertions assume a few things about the inputs. All inputs are synchronous to clk_i. dev_clk_i toggles only in remote mode, and its phases last several system cycles. The remote buffer changes data and ready only after a falling clock edge and well inside the settling delay. The bench's buffer model meets these assumptions. It updates rdy_i and dat_i on the negative edge that follows a clock fall it has seen. It drives dev_clk_i with phases of three or more cycles, and only while mode_o is 0. Request pulses are one cycle wide and are issued only in the mode they apply to.

// File: rtl/rdr_pkg.sv
package rdr_pkg;
  typedef enum logic [2:0] {S_DEV, S_TAKE, S_IDLE, S_HIGH, S_LOW} rdr_state_e;
  typedef enum logic [1:0] {G_NONE, G_DRAIN, G_ARM, G_LAST} rdr_give_e;
endpackage

// File: rtl/rdr_deser.sv
module rdr_deser #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         shift_i,
  input  logic         bit_i,
  input  logic         ready_i,
  output logic [W-1:0] data_o,
  output logic         valid_o,
  output logic         last_o
);
  localparam int unsigned CW = $clog2(W);

  logic [W-2:0] sh_q;
  logic [CW-1:0] cnt_q;
  logic [W-1:0] data_q;
  logic          valid_q;

  assign last_o  = (cnt_q == CW'(W-1));
  assign data_o  = data_q;
  assign valid_o = valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q    <= '0;
      cnt_q   <= '0;
      data_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      if (valid_q && ready_i) valid_q <= 1'b0;
      if (shift_i) begin
        if (last_o) begin
          cnt_q <= '0;
          // a held word is never replaced; host side never gets here stalled
          if (!valid_q || ready_i) begin
            data_q  <= {sh_q, bit_i};
            valid_q <= 1'b1;
          end
        end else begin
          sh_q  <= {sh_q[W-3:0], bit_i};
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  a_r6_hold_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q && !ready_i |=> valid_q && $stable(data_q));

  a_r5_count_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(W-1));
endmodule

// File: rtl/rdr_window.sv
module rdr_window #(
  parameter int unsigned LIMIT = 105000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic run_i,
  output logic expired_o
);
  localparam int unsigned CW = $clog2(LIMIT+1);

  logic [CW-1:0] cnt_q;
  logic          at_end;

  assign at_end    = (cnt_q == CW'(LIMIT-1));
  assign expired_o = run_i && at_end;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (start_i)           cnt_q <= '0;
    else if (run_i && !at_end)  cnt_q <= cnt_q + 1'b1;
  end

  a_r10_fresh_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !expired_o);
endmodule

// File: rtl/rdr_host_reader.sv
module rdr_host_reader
  import rdr_pkg::*;
#(
  parameter int unsigned W          = 8,
  parameter int unsigned HI_CYC     = 94,
  parameter int unsigned LO_CYC     = 94,
  parameter int unsigned SETTLE_CYC = 94,
  parameter int unsigned TMS_CYC    = 105000
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         rdy_i,
  input  logic         dat_i,
  input  logic         dev_clk_i,
  output logic         sclk_o,
  output logic         mode_o,
  input  logic         take_req_i,
  input  logic         give_req_i,
  output logic [W-1:0] byte_o,
  output logic         byte_valid_o,
  input  logic         byte_ready_i,
  output logic         err_o
);
  localparam int unsigned WAIT_CYC = (LO_CYC > SETTLE_CYC) ? LO_CYC : SETTLE_CYC;
  localparam int unsigned PH_MAX   = (HI_CYC > WAIT_CYC) ? HI_CYC : WAIT_CYC;
  localparam int unsigned PW       = $clog2(PH_MAX+1);

  rdr_state_e st_q, st_d;
  rdr_give_e  give_q, give_d;
  logic [PW-1:0] ph_q, ph_d;
  logic pulsed_q, pulsed_d;
  logic mode_q, mode_d;
  logic err_q, err_d;
  logic sclk_q;
  logic dev_clk_q, dev_fall;
  logic shift, go, win_start, win_run, expired;
  logic last_bit, stall;

  assign dev_fall = dev_clk_q && !dev_clk_i;
  assign stall    = last_bit && byte_valid_o;
  assign win_run  = (st_q == S_TAKE) || (give_q == G_LAST);

  rdr_deser #(.W(W)) i_deser (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .shift_i (shift),
    .bit_i   (dat_i),
    .ready_i (byte_ready_i),
    .data_o  (byte_o),
    .valid_o (byte_valid_o),
    .last_o  (last_bit)
  );

  rdr_window #(.LIMIT(TMS_CYC)) i_window (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (win_start),
    .run_i     (win_run),
    .expired_o (expired)
  );

  always_comb begin
    st_d      = st_q;
    give_d    = give_q;
    ph_d      = ph_q;
    pulsed_d  = pulsed_q;
    mode_d    = mode_q;
    err_d     = err_q;
    win_start = 1'b0;
    shift     = 1'b0;
    go        = 1'b0;

    if (mode_q && give_q == G_NONE && give_req_i) give_d = G_DRAIN;

    unique case (st_q)
      S_DEV: begin
        shift = dev_fall;
        if (take_req_i) begin
          st_d      = S_TAKE;
          win_start = 1'b1;
        end
      end
      S_TAKE: begin
        shift = dev_fall;
        if (dev_fall) begin
          mode_d = 1'b1;
          give_d = G_NONE;
          st_d   = S_IDLE;
        end else if (expired) begin
          err_d = 1'b1;
          st_d  = S_DEV;
        end
      end
      S_HIGH: begin
        if (ph_q == '0) begin
          shift = 1'b1;   // capture on the falling edge
          st_d  = S_LOW;
          ph_d  = PW'(WAIT_CYC-1);
        end else begin
          ph_d = ph_q - 1'b1;
        end
      end
      S_LOW: begin
        if (ph_q == '0) st_d = S_IDLE;
        else            ph_d = ph_q - 1'b1;
      end
      S_IDLE: begin
        unique case (give_q)
          G_NONE: go = rdy_i && !stall;
          G_DRAIN: begin
            if (!rdy_i) give_d = G_ARM;
            else        go     = !stall;
          end
          G_ARM: begin
            if (rdy_i) begin
              give_d    = G_LAST;
              win_start = 1'b1;
              pulsed_d  = 1'b0;
              go        = !stall;
            end
          end
          G_LAST: begin
            if (expired || (pulsed_q && !rdy_i)) begin
              err_d  = err_q || expired;
              mode_d = 1'b0;
              give_d = G_NONE;
              st_d   = S_DEV;
            end else begin
              go = rdy_i && !stall;
            end
          end
          default: ;
        endcase
        if (go) begin
          st_d = S_HIGH;
          ph_d = PW'(HI_CYC-1);
          if (give_d == G_LAST) pulsed_d = 1'b1;
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= S_IDLE;
      give_q    <= G_NONE;
      ph_q      <= '0;
      pulsed_q  <= 1'b0;
      mode_q    <= 1'b1;
      err_q     <= 1'b0;
      sclk_q    <= 1'b0;
      dev_clk_q <= 1'b0;
    end else begin
      st_q      <= st_d;
      give_q    <= give_d;
      ph_q      <= ph_d;
      pulsed_q  <= pulsed_d;
      mode_q    <= mode_d;
      err_q     <= err_d;
      sclk_q    <= (st_d == S_HIGH);
      dev_clk_q <= dev_clk_i;
    end
  end

  assign sclk_o = sclk_q;
  assign mode_o = mode_q;
  assign err_o  = err_q;

  // checker-only run length of the high phase
  logic [PW-1:0] hi_run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     hi_run_q <= '0;
    else if (sclk_q) hi_run_q <= hi_run_q + 1'b1;
    else             hi_run_q <= '0;
  end

  a_r2_rise_needs_rdy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sclk_q) |-> $past(rdy_i));

  a_r3_high_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sclk_q) |-> hi_run_q == PW'(HI_CYC));

  a_r8_dev_clk_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_q |-> !sclk_q);

  a_r6_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_q |-> !stall);

  a_r11_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$fell(err_q));
endmodule

// File: tb/test_rdr_host_reader.sv
module test_rdr_host_reader;
  localparam int HI = 3, LO = 2, SET = 4, TMS = 200, WAITC = 4;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic rdy_i = 1'b0, dat_i = 1'b0, dev_clk_i = 1'b0;
  logic take_req_i = 1'b0, give_req_i = 1'b0, byte_ready_i = 1'b1;
  logic sclk_o, mode_o, byte_valid_o, err_o;
  logic [7:0] byte_o;

  always #4 clk = ~clk;

  rdr_host_reader #(.W(8), .HI_CYC(HI), .LO_CYC(LO), .SETTLE_CYC(SET), .TMS_CYC(TMS)) i_rdr_host_reader (
    .clk_i(clk), .rst_ni(rst_ni), .rdy_i(rdy_i), .dat_i(dat_i), .dev_clk_i(dev_clk_i),
    .sclk_o(sclk_o), .mode_o(mode_o), .take_req_i(take_req_i), .give_req_i(give_req_i),
    .byte_o(byte_o), .byte_valid_o(byte_valid_o), .byte_ready_i(byte_ready_i), .err_o(err_o));

  int n_chk = 0, n_err = 0;
  bit done = 0;
  bit rq[$];
  logic [7:0] exq[$];
  int pulses = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // remote buffer model and monitors
  logic sclk_p = 1'b0, dev_p = 1'b0, pop_dev = 1'b0;
  int hi_len = 0, lo_len = 0;
  bit seen_fall = 0;
  always @(negedge clk) begin
    if (pop_dev && rq.size() > 0) void'(rq.pop_front());
    pop_dev = dev_p && !dev_clk_i;
    dev_p   = dev_clk_i;
    if (sclk_p && !sclk_o && rq.size() > 0) void'(rq.pop_front());
    if (sclk_o && !sclk_p) begin
      pulses++;
      if (seen_fall) chk(lo_len >= WAITC + 1, "R3 low gap", lo_len, WAITC + 1);
    end
    if (!sclk_o && sclk_p) begin
      chk(hi_len == HI, "R3 high width", hi_len, HI);
      seen_fall = 1; lo_len = 0;
    end
    if (sclk_o) hi_len++; else hi_len = 0;
    if (!sclk_o) lo_len++;
    sclk_p = sclk_o;
    rdy_i = (rq.size() > 0);
    dat_i = (rq.size() > 0) ? rq[0] : 1'b0;
    if (rst_ni && byte_valid_o && byte_ready_i) begin
      if (exq.size() == 0) chk(0, "R5 unexpected word", byte_o, 0);
      else begin
        logic [7:0] e;
        e = exq.pop_front();
        chk(byte_o == e, "R5 word value", byte_o, e);
      end
    end
  end

  task automatic push_bits(input logic [7:0] v, input int hi, input int lo);
    for (int i = hi; i >= lo; i--) rq.push_back(v[i]);
  endtask

  task automatic push_byte(input logic [7:0] v);
    push_bits(v, 7, 0);
    exq.push_back(v);
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wait_exp;
    while (exq.size() != 0) cyc(1);
    cyc(2);
  endtask

  task automatic dev_pulse;
    cyc(1); dev_clk_i = 1'b1;
    cyc(3); dev_clk_i = 1'b0;
    cyc(3);
  endtask

  task automatic req_pulse(input bit take);
    cyc(1);
    if (take) take_req_i = 1'b1; else give_req_i = 1'b1;
    cyc(1);
    take_req_i = 1'b0; give_req_i = 1'b0;
  endtask

  // {data, cycles with byte_ready low}
  localparam logic [15:0] VEC [8] = '{
    16'hA5_00, 16'h00_05, 16'hFF_00, 16'h3C_1A,
    16'h81_02, 16'h7E_00, 16'h01_30, 16'h80_01};

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      chk(0, "watchdog", 0, 1);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    int p0, t;
    cyc(3);
    chk(mode_o == 1'b1, "R1 mode in reset", mode_o, 1);
    @(negedge clk); rst_ni = 1'b1;
    cyc(2);
    chk(mode_o == 1'b1, "R1 mode", mode_o, 1);
    chk(sclk_o == 1'b0, "R1 sclk", sclk_o, 0);
    chk(byte_valid_o == 1'b0, "R1 valid", byte_valid_o, 0);
    chk(err_o == 1'b0, "R1 err", err_o, 0);

    // R5 R3 R4: vector walk
    for (int k = 0; k < 8; k++) begin
      push_byte(VEC[k][15:8]);
      byte_ready_i = 1'b0;
      cyc(int'(VEC[k][7:0]));
      byte_ready_i = 1'b1;
      wait_exp;
    end
    cyc(20);
    chk(pulses == 64, "R4 pulse count", pulses, 64);
    chk(rq.size() == 0, "R4 buffer drained", rq.size(), 0);

    // R2 R7: long idle with ready low
    p0 = pulses;
    cyc(3 * TMS);
    chk(pulses == p0, "R2 no pulse while ready low", pulses, p0);
    chk(sclk_o == 1'b0, "R2 sclk low", sclk_o, 0);
    chk(err_o == 1'b0, "R7 no error on long low", err_o, 0);

    // R6: stall
    byte_ready_i = 1'b0;
    p0 = pulses;
    push_byte(8'h4B); push_byte(8'hD2); push_byte(8'h69);
    cyc(300);
    chk(pulses - p0 == 15, "R6 stall pulses", pulses - p0, 15);
    chk(rq.size() == 9, "R6 bits left", rq.size(), 9);
    chk(byte_valid_o && byte_o == 8'h4B, "R6 held word", byte_o, 8'h4B);
    byte_ready_i = 1'b1;
    wait_exp;

    // R10 R7: hand back, single bit on host side
    req_pulse(0);
    cyc(3 * TMS);
    chk(mode_o == 1'b1, "R10 kept until ready rises", mode_o, 1);
    chk(err_o == 1'b0, "R7 no error while armed", err_o, 0);
    p0 = pulses;
    exq.push_back(8'hC9);
    push_bits(8'hC9, 7, 7);
    t = 0;
    while (mode_o && t < 2 * TMS) begin cyc(1); t++; end
    chk(t <= TMS, "R10 release window", t, TMS);
    chk(mode_o == 1'b0, "R10 released", mode_o, 0);
    chk(pulses - p0 == 1, "R10 one bit", pulses - p0, 1);

    // R8: remote-clocked bits
    push_bits(8'hC9, 6, 0);
    p0 = pulses;
    for (int i = 0; i < 7; i++) dev_pulse;
    wait_exp;
    chk(pulses == p0, "R8 no host pulse", pulses, p0);

    // R9: takeover mid-word
    push_byte(8'h5A); push_byte(8'hE1);
    for (int i = 0; i < 5; i++) dev_pulse;
    req_pulse(1);
    p0 = pulses;
    dev_pulse;
    chk(mode_o == 1'b1, "R9 mode taken", mode_o, 1);
    wait_exp;
    chk(rq.size() == 0, "R9 drained", rq.size(), 0);
    chk(pulses - p0 == 10, "R9 host bits", pulses - p0, 10);

    // R10 again, full word, then R11 takeover timeout
    req_pulse(0);
    cyc(20);
    push_byte(8'h96);
    t = 0;
    while (mode_o && t < 2 * TMS) begin cyc(1); t++; end
    chk(mode_o == 1'b0 && err_o == 1'b0, "R10 release after word", {mode_o, err_o}, 0);
    wait_exp;
    req_pulse(1);
    cyc(TMS + 10);
    chk(err_o == 1'b1, "R11 timeout flag", err_o, 1);
    chk(mode_o == 1'b0, "R11 mode kept", mode_o, 0);
    cyc(50);
    chk(err_o == 1'b1, "R11 sticky", err_o, 1);

    // R1 again
    @(negedge clk); rst_ni = 1'b0;
    cyc(3);
    chk(mode_o == 1'b1 && err_o == 1'b0 && byte_valid_o == 1'b0, "R1 re-reset",
        {mode_o, err_o, byte_valid_o}, 3'b100);
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule